// File: doc/BRIEF.md
# NAND Flash Bus Glue Decoder

This block connects one chip-select window of a processor's external bus to as many as two 8-bit NAND flash devices and to a small halfword register space. Upper address lines choose the target: flash slot A, flash slot B, or the register space. Two fixed low address lines choose whether a flash write is a command byte or an address byte. Nothing has to be programmed first, so software selects a device and a latch type only through the address it uses.

Each bus cycle is sampled on the clock edge and turned into one registered access state. The states are `ST_IDLE`, `ST_FLASH_RD`, `ST_FLASH_WR`, `ST_REG_RD` and `ST_REG_WR`. Every edge re-evaluates the next state from the live bus:
- The block goes to `ST_IDLE` when the bus chip-select is high, when the read and write strobes are both low or both high, or when the target code is not decoded.
- A valid flash read or write goes to `ST_FLASH_RD` or `ST_FLASH_WR`.
- A valid register-space read or write goes to `ST_REG_RD` or `ST_REG_WR`.

All outputs follow from the current state and the values captured with it. This means the flash pins and the read data follow the bus with one clock of latency.

The register space holds one status word. Its bit 0 reports the ready/busy line of the flash slot that was accessed last, brought into the clock domain through a two-flop synchroniser.

Top module: `nbg_nand_glue`

## Requirements
- R1: While reset is asserted, every flash chip enable, read strobe and write strobe is high (inactive), both latch enables and the data-drive enable are low, and `bus_rdata` is zero, whatever the bus does.
- R2: The target field is address bits 24..22. Code 3'b010 selects slot A (`nand_ce_n[0]`), code 3'b011 selects slot B (`nand_ce_n[1]`), and code 3'b100 selects the register space. Every other code selects nothing, and no flash pin moves.
- R3: At most one chip enable is low at any time. It is the enable of the decoded slot. All chip enables stay high in any cycle that follows a cycle with the bus chip-select high.
- R4: On a flash write, address bit 5 high drives `nand_cle` high. Address bit 4 high drives `nand_ale` high only when bit 5 is low. Both latch enables stay low on reads and outside flash writes.
- R5: A flash read drives `nand_re_n` low and returns the device byte on `bus_rdata[7:0]`, with the upper bits zero and `nand_we_n` high.
- R6: A flash write drives `nand_we_n` low and `nand_doe` high, and places `bus_wdata[7:0]` on `nand_dout`. The upper write-data bits have no effect.
- R7: A register-space access never asserts a chip enable, a read strobe or a write strobe.
- R8: A register read at byte offset 0x02 returns the ready flag in bit 0 (1 = ready) with all other bits zero. Other offsets read as zero, and register writes change nothing that a later read shows.
- R9: The ready flag is the ready/busy input of the last flash slot accessed (slot A after reset), passed through two flops. A change on the input becomes readable after the second clock edge.
- R10: Flash pins and read data reflect the bus inputs sampled at the previous clock edge.
- R11: A bus cycle with both read and write strobes low is ignored: no chip enable and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Bus chip-select for the window, active low |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_addr | input | 25 | Bus byte address |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data |
| nand_ce_n | output | 2 | Per-slot flash chip enables, active low |
| nand_cle | output | 1 | Flash command-latch enable |
| nand_ale | output | 1 | Flash address-latch enable |
| nand_re_n | output | 1 | Flash read enable, active low |
| nand_we_n | output | 1 | Flash write enable, active low |
| nand_dout | output | 8 | Byte driven toward the flash data bus |
| nand_doe | output | 1 | Drive enable for `nand_dout` |
| nand_din | input | 8 | Byte returned by the flash data bus |
| nand_rb | input | 2 | Per-slot ready/busy lines, 1 = ready |

## Verification
The assertions check these properties on every cycle:
- At most one chip enable is low.
- An idle chip-select and a register-space access leave every flash strobe and chip enable inactive.
- The two latch enables never rise together and rise only inside a flash write.
- The two flash strobes never overlap.
- A cycle with both strobes low produces no strobe.

Only the bench scenarios can show the values carried through the block:
- which slot code reaches which chip enable;
- the command-over-address priority;
- the byte returned on a read;
- the status word with its offset decode;
- the two-edge delay of the ready flag and its following of the last slot accessed.

// File: rtl/nbg_pkg.sv
package nbg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLASH_RD,
        ST_FLASH_WR,
        ST_REG_RD,
        ST_REG_WR
    } acc_state_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_SLOT,
        TGT_REGS
    } target_e;

endpackage

// File: rtl/nbg_addr_decode.sv
module nbg_addr_decode
    import nbg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 25,
    parameter int unsigned SEL_LSB    = 22,
    parameter int unsigned SEL_W      = 3,
    parameter int unsigned SLOT_CODE0 = 2,
    parameter int unsigned REG_CODE   = 4,
    parameter int unsigned NUM_SLOTS  = 2,
    parameter int unsigned CLE_BIT    = 5,
    parameter int unsigned ALE_BIT    = 4,
    parameter int unsigned OFF_W      = 8,
    parameter int unsigned STATUS_OFF = 2,
    localparam int unsigned SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output target_e           target,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              cle_req,
    output logic              ale_req,
    output logic              status_hit
);

    logic [SEL_W-1:0]     sel_field;
    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 unused_addr;

    assign sel_field   = addr[SEL_LSB +: SEL_W];
    assign unused_addr = ^addr;

    // one comparator per flash slot, codes are consecutive from SLOT_CODE0
    for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot_cmp
        localparam logic [SEL_W-1:0] CODE_I = SEL_W'(SLOT_CODE0 + gi);
        assign slot_hit[gi] = (sel_field == CODE_I);
    end

    always_comb begin
        slot_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (slot_hit[i]) slot_idx = SLOT_W'(i);
        end
    end

    always_comb begin
        if (|slot_hit)                          target = TGT_SLOT;
        else if (sel_field == SEL_W'(REG_CODE)) target = TGT_REGS;
        else                                    target = TGT_NONE;
    end

    assign cle_req    = addr[CLE_BIT];
    assign ale_req    = addr[ALE_BIT];
    assign status_hit = (addr[OFF_W-1:0] == OFF_W'(STATUS_OFF));

endmodule

// File: rtl/nbg_rb_sync.sv
module nbg_rb_sync #(
    parameter int unsigned NUM_SLOTS = 2,
    parameter int unsigned STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] rb_async,
    output logic [NUM_SLOTS-1:0] rb_sync
);

    for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_sync
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], rb_async[gi]};
        end
        assign rb_sync[gi] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/nbg_access_fsm.sv
module nbg_access_fsm
    import nbg_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 2,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned FLASH_W   = 8,
    localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_cs_n,
    input  logic                 bus_rd_n,
    input  logic                 bus_wr_n,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  target_e              target,
    input  logic [SLOT_W-1:0]    dec_slot,
    input  logic                 cle_req,
    input  logic                 ale_req,
    input  logic                 status_hit,
    input  logic                 ready_bit,
    input  logic [FLASH_W-1:0]   nand_din,
    output logic [SLOT_W-1:0]    last_slot,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_SLOTS-1:0] nand_ce_n,
    output logic                 nand_cle,
    output logic                 nand_ale,
    output logic                 nand_re_n,
    output logic                 nand_we_n,
    output logic [FLASH_W-1:0]   nand_dout,
    output logic                 nand_doe
);

    acc_state_e         state_q, state_d;
    logic [SLOT_W-1:0]  slot_q;
    logic               cle_q, ale_q, stat_q;
    logic [FLASH_W-1:0] wbyte_q;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign last_slot    = slot_q;

    // next-state decision from the live bus
    always_comb begin
        state_d = ST_IDLE;
        if (!bus_cs_n && (bus_rd_n != bus_wr_n)) begin
            unique case (target)
                TGT_SLOT: state_d = !bus_rd_n ? ST_FLASH_RD : ST_FLASH_WR;
                TGT_REGS: state_d = !bus_rd_n ? ST_REG_RD   : ST_REG_WR;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register and the values captured alongside it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            cle_q   <= 1'b0;
            ale_q   <= 1'b0;
            stat_q  <= 1'b0;
            wbyte_q <= '0;
        end else begin
            state_q <= state_d;
            cle_q   <= cle_req;
            ale_q   <= ale_req;
            stat_q  <= status_hit;
            wbyte_q <= bus_wdata[FLASH_W-1:0];
            if (state_d == ST_FLASH_RD || state_d == ST_FLASH_WR) slot_q <= dec_slot;
        end
    end

    // outputs from the current state
    always_comb begin
        nand_ce_n = '1;
        nand_re_n = 1'b1;
        nand_we_n = 1'b1;
        nand_cle  = 1'b0;
        nand_ale  = 1'b0;
        nand_doe  = 1'b0;
        nand_dout = '0;
        bus_rdata = '0;
        unique case (state_q)
            ST_FLASH_RD: begin
                nand_ce_n[slot_q] = 1'b0;
                nand_re_n         = 1'b0;
                bus_rdata         = {{(DATA_W-FLASH_W){1'b0}}, nand_din};
            end
            ST_FLASH_WR: begin
                nand_ce_n[slot_q] = 1'b0;
                nand_we_n         = 1'b0;
                nand_doe          = 1'b1;
                nand_dout         = wbyte_q;
                nand_cle          = cle_q;
                nand_ale          = ale_q & ~cle_q;
            end
            ST_REG_RD: begin
                if (stat_q) bus_rdata = {{(DATA_W-1){1'b0}}, ready_bit};
            end
            ST_REG_WR: begin
                bus_rdata = '0;
            end
            ST_IDLE: begin
                bus_rdata = '0;
            end
            default: begin
                bus_rdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/nbg_nand_glue.sv
module nbg_nand_glue
    import nbg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 25,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned FLASH_W    = 8,
    parameter int unsigned NUM_SLOTS  = 2,
    parameter int unsigned SEL_LSB    = 22,
    parameter int unsigned SEL_W      = 3,
    parameter int unsigned SLOT_CODE0 = 2,
    parameter int unsigned REG_CODE   = 4,
    parameter int unsigned CLE_BIT    = 5,
    parameter int unsigned ALE_BIT    = 4,
    parameter int unsigned OFF_W      = 8,
    parameter int unsigned STATUS_OFF = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_cs_n,
    input  logic                 bus_rd_n,
    input  logic                 bus_wr_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_SLOTS-1:0] nand_ce_n,
    output logic                 nand_cle,
    output logic                 nand_ale,
    output logic                 nand_re_n,
    output logic                 nand_we_n,
    output logic [FLASH_W-1:0]   nand_dout,
    output logic                 nand_doe,
    input  logic [FLASH_W-1:0]   nand_din,
    input  logic [NUM_SLOTS-1:0] nand_rb
);

    localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    target_e              dec_target;
    logic [SLOT_W-1:0]    dec_slot;
    logic [SLOT_W-1:0]    last_slot;
    logic                 dec_cle, dec_ale, dec_status;
    logic [NUM_SLOTS-1:0] rb_sync;
    logic                 ready_bit;

    nbg_addr_decode #(
        .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W),
        .SLOT_CODE0(SLOT_CODE0), .REG_CODE(REG_CODE), .NUM_SLOTS(NUM_SLOTS),
        .CLE_BIT(CLE_BIT), .ALE_BIT(ALE_BIT), .OFF_W(OFF_W), .STATUS_OFF(STATUS_OFF)
    ) decode_i (
        .addr      (bus_addr),
        .target    (dec_target),
        .slot_idx  (dec_slot),
        .cle_req   (dec_cle),
        .ale_req   (dec_ale),
        .status_hit(dec_status)
    );

    nbg_rb_sync #(
        .NUM_SLOTS(NUM_SLOTS), .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rb_async(nand_rb),
        .rb_sync (rb_sync)
    );

    assign ready_bit = rb_sync[last_slot];

    nbg_access_fsm #(
        .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .FLASH_W(FLASH_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs_n  (bus_cs_n),
        .bus_rd_n  (bus_rd_n),
        .bus_wr_n  (bus_wr_n),
        .bus_wdata (bus_wdata),
        .target    (dec_target),
        .dec_slot  (dec_slot),
        .cle_req   (dec_cle),
        .ale_req   (dec_ale),
        .status_hit(dec_status),
        .ready_bit (ready_bit),
        .nand_din  (nand_din),
        .last_slot (last_slot),
        .bus_rdata (bus_rdata),
        .nand_ce_n (nand_ce_n),
        .nand_cle  (nand_cle),
        .nand_ale  (nand_ale),
        .nand_re_n (nand_re_n),
        .nand_we_n (nand_we_n),
        .nand_dout (nand_dout),
        .nand_doe  (nand_doe)
    );

endmodule

// File: rtl/nbg_checker.sv
module nbg_checker #(
    parameter int unsigned ADDR_W    = 25,
    parameter int unsigned NUM_SLOTS = 2,
    parameter int unsigned SEL_LSB   = 22,
    parameter int unsigned SEL_W     = 3,
    parameter int unsigned REG_CODE  = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_cs_n,
    input logic                 bus_rd_n,
    input logic                 bus_wr_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [NUM_SLOTS-1:0] nand_ce_n,
    input logic                 nand_cle,
    input logic                 nand_ale,
    input logic                 nand_re_n,
    input logic                 nand_we_n,
    input logic                 nand_doe
);

    logic reg_access;
    assign reg_access = !bus_cs_n && (bus_addr[SEL_LSB +: SEL_W] == SEL_W'(REG_CODE));

    AST_CE_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n)); // R3

    AST_NO_CE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |=> (&nand_ce_n)); // R3

    AST_REG_NEVER_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        reg_access |=> (nand_re_n && nand_we_n && (&nand_ce_n))); // R7

    AST_LATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R4

    AST_LATCH_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle || nand_ale) |-> !nand_we_n); // R4

    AST_DRIVE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        nand_doe |-> !nand_we_n); // R6

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_re_n && !nand_we_n)); // R5

    AST_DOUBLE_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !bus_rd_n && !bus_wr_n) |=> (nand_re_n && nand_we_n && (&nand_ce_n))); // R11

endmodule

bind nbg_nand_glue nbg_checker #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .SEL_LSB(SEL_LSB),
    .SEL_W(SEL_W), .REG_CODE(REG_CODE)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_addr (bus_addr),
    .nand_ce_n(nand_ce_n),
    .nand_cle (nand_cle),
    .nand_ale (nand_ale),
    .nand_re_n(nand_re_n),
    .nand_we_n(nand_we_n),
    .nand_doe (nand_doe)
);

// File: tb/nbg_nand_glue_tb_top.sv
module nbg_nand_glue_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [24:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_re_n, nand_we_n, nand_doe;
    logic [7:0]  nand_dout;
    logic [7:0]  nand_din = '0;
    logic [1:0]  nand_rb = 2'b11;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nbg_nand_glue dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_re_n(nand_re_n), .nand_we_n(nand_we_n),
        .nand_dout(nand_dout), .nand_doe(nand_doe), .nand_din(nand_din),
        .nand_rb(nand_rb)
    );

    typedef struct packed {
        logic        cs_n, rd_n, wr_n;
        logic [24:0] addr;
        logic [15:0] wdata;
        logic [7:0]  din;
        logic [1:0]  e_ce;
        logic        e_re, e_we, e_cle, e_ale, e_doe;
        logic [7:0]  e_dout;
        logic [15:0] e_rdata;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b0, 25'h080_0020, 16'h1234, 8'h00, 2'b11,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 16'h0000},
        '{1'b0,1'b1,1'b0, 25'h080_0020, 16'h1234, 8'h00, 2'b10,1'b1,1'b0,1'b1,1'b0,1'b1, 8'h34, 16'h0000},
        '{1'b0,1'b1,1'b0, 25'h080_0010, 16'h00A5, 8'h00, 2'b10,1'b1,1'b0,1'b0,1'b1,1'b1, 8'hA5, 16'h0000},
        '{1'b0,1'b1,1'b0, 25'h080_0030, 16'h005A, 8'h00, 2'b10,1'b1,1'b0,1'b1,1'b0,1'b1, 8'h5A, 16'h0000},
        '{1'b0,1'b1,1'b0, 25'h0C0_0000, 16'h0077, 8'h00, 2'b01,1'b1,1'b0,1'b0,1'b0,1'b1, 8'h77, 16'h0000},
        '{1'b0,1'b0,1'b1, 25'h0C0_0020, 16'h0000, 8'hC3, 2'b01,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00, 16'h00C3},
        '{1'b0,1'b0,1'b1, 25'h080_0000, 16'h0000, 8'h3C, 2'b10,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00, 16'h003C},
        '{1'b0,1'b0,1'b1, 25'h100_0002, 16'h0000, 8'hFF, 2'b11,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 16'h0001},
        '{1'b0,1'b0,1'b1, 25'h100_0004, 16'h0000, 8'hFF, 2'b11,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 16'h0000},
        '{1'b0,1'b1,1'b0, 25'h100_0002, 16'hFFFF, 8'h00, 2'b11,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 16'h0000},
        '{1'b0,1'b1,1'b0, 25'h140_0020, 16'h0011, 8'h00, 2'b11,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 16'h0000},
        '{1'b0,1'b0,1'b1, 25'h000_0000, 16'h0000, 8'h99, 2'b11,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 16'h0000},
        '{1'b0,1'b0,1'b0, 25'h080_0020, 16'h0022, 8'h44, 2'b11,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 16'h0000},
        '{1'b0,1'b1,1'b0, 25'h0C0_0010, 16'hAB55, 8'h00, 2'b01,1'b1,1'b0,1'b0,1'b1,1'b1, 8'h55, 16'h0000}
    };

    function automatic string row_tag(input int idx);
        case (idx)
            0:       return "R3 idle chip-select";
            1:       return "R4/R6 command write slot A";
            2:       return "R4 address write slot A";
            3:       return "R4 command over address priority";
            4:       return "R2 slot B write";
            5:       return "R5 slot B read, no latch on read";
            6:       return "R5 slot A read";
            7:       return "R8 status read ready";
            8:       return "R8 other offset reads zero";
            9:       return "R7 register write no strobe";
            10:      return "R2 undecoded code 101";
            11:      return "R2 undecoded code 000";
            12:      return "R11 both strobes low";
            default: return "R6 upper write data ignored";
        endcase
    endfunction

    function automatic logic [30:0] pins();
        return {nand_ce_n, nand_re_n, nand_we_n, nand_cle, nand_ale, nand_doe, nand_dout, bus_rdata};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic cs_n, input logic rd_n, input logic wr_n,
                         input logic [24:0] addr, input logic [15:0] wdata);
        bus_cs_n  = cs_n;
        bus_rd_n  = rd_n;
        bus_wr_n  = wr_n;
        bus_addr  = addr;
        bus_wdata = wdata;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1: outputs stay inactive under reset even with a live flash write
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 25'h080_0020, 16'h00EE);
        step();
        step();
        check("R1 reset pins", {1'b0, pins()}, {1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000});
        drive(1'b1, 1'b1, 1'b1, 25'h0, 16'h0);
        rst_n = 1'b1;
        repeat (4) step();

        // R10: each row is driven, one edge passes, the result is sampled
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].cs_n, VECS[i].rd_n, VECS[i].wr_n, VECS[i].addr, VECS[i].wdata);
            nand_din = VECS[i].din;
            step();
            check(row_tag(i), {1'b0, pins()},
                  {1'b0, VECS[i].e_ce, VECS[i].e_re, VECS[i].e_we, VECS[i].e_cle,
                   VECS[i].e_ale, VECS[i].e_doe, VECS[i].e_dout, VECS[i].e_rdata});
        end

        // R10: the output changes only after the edge that samples the bus
        drive(1'b1, 1'b1, 1'b1, 25'h0, 16'h0);
        step();
        drive(1'b0, 1'b1, 1'b0, 25'h080_0000, 16'h0001);
        #1;
        check("R10 no change before edge", {31'b0, nand_we_n}, 32'd1);
        step();
        check("R10 change after edge", {31'b0, nand_we_n}, 32'd0);

        // R9: slot B busy, slot A ready; last access to B gives busy
        drive(1'b1, 1'b1, 1'b1, 25'h0, 16'h0);
        nand_rb = 2'b01;
        repeat (3) step();
        drive(1'b0, 1'b0, 1'b1, 25'h0C0_0000, 16'h0);
        step();
        drive(1'b0, 1'b0, 1'b1, 25'h100_0002, 16'h0);
        step();
        check("R9 follows last slot B busy", {16'h0, bus_rdata}, 32'h0000_0000);

        drive(1'b0, 1'b0, 1'b1, 25'h080_0000, 16'h0);
        step();
        drive(1'b0, 1'b0, 1'b1, 25'h100_0002, 16'h0);
        step();
        check("R9 follows last slot A ready", {16'h0, bus_rdata}, 32'h0000_0001);

        // R9: two-flop latency on the ready input
        nand_rb = 2'b00;
        step();
        check("R9 old value after one edge", {16'h0, bus_rdata}, 32'h0000_0001);
        step();
        check("R9 new value after two edges", {16'h0, bus_rdata}, 32'h0000_0000);

        // R8: a register write leaves the status word unchanged
        nand_rb = 2'b11;
        repeat (3) step();
        drive(1'b0, 1'b1, 1'b0, 25'h100_0002, 16'h0000);
        step();
        drive(1'b0, 1'b0, 1'b1, 25'h100_0002, 16'h0);
        step();
        check("R8 status unaffected by write", {16'h0, bus_rdata}, 32'h0000_0001);

        // R3: chip-select high after a flash access returns every enable high
        drive(1'b1, 1'b0, 1'b1, 25'h0C0_0000, 16'h0);
        step();
        check("R3 enables high after deselect", {30'b0, nand_ce_n}, 32'd3);

        finish_run();
    end

endmodule